// File: doc/BRIEF.md
# Cache ECC Error Status Registers

This block collects ECC error reports from a cache and presents them to software through a small 32-bit register port. Three error classes are reported, each by a one-cycle event pulse that comes with a 64-bit failing address:

- directory errors that were corrected,
- data errors that were corrected,
- data errors that could not be corrected.

For each class the block keeps the most recent failing address and a saturating event count. It also raises a level interrupt that stays high until software reads that class's count register.

The same port exposes three further registers:

- a read-only geometry word that describes the cache;
- a register that limits the highest enabled way;
- an error-injection control register. Accepted writes to it are passed to the cache's ECC logic as control outputs plus a one-cycle trigger.

A read is requested in one cycle, and its data comes back registered in the next cycle with `rvalid_o`. Any side effect of a read takes place on the clock edge that accepts the request.

Top module: `cache_ecc_status`

## Requirements
- R1: After synchronous reset, all interrupts, counts, captured addresses, the way limit and the injection register read as zero, and `inj_go_o` is low.
- R2: An event pulse on class c captures its 64-bit address on the same clock edge. The low word is at offset base+0x0 and the high word at base+0x4, where base is 0x100 for directory-corrected (class 0), 0x140 for data-corrected (class 1) and 0x160 for data-uncorrected (class 2). A later event overwrites the address, so the last error wins.
- R3: Each event adds one to that class's count. The count is read zero-extended at base+0x8 and saturates at 2^CNT_W-1.
- R4: An event sets `irq_o[c]`. The interrupt stays high until a read of that class's count register, and reading the address words does not clear it.
- R5: When an event and a count read of the same class fall in the same cycle, the read returns the count from before the event, the count still increments, and the interrupt stays high.
- R6: The classes are independent: an event on one class, or a read of one class's count, leaves every other class's interrupt, count and address unchanged.
- R7: Offset 0x00 is a read-only geometry word, and writes to it are ignored. Its fields are: bank count in bits 7:0, ways per bank in 15:8, log2 of sets per bank in 23:16, and log2 of bytes per block in 31:24.
- R8: Offset 0x08 holds the index of the largest enabled way, output on `way_max_o`. A write is accepted only when the value is at most WAYS-1; any other write is ignored.
- R9: Offset 0x40 is the injection register, with the bit select in bits 7:0 and the target selector in bit 16. A write is accepted only when bits 7:0 are not 0xFF and every other bit except 16 is zero. An accepted write updates `inj_bit_o` and `inj_sel_o` and pulses `inj_go_o` high for exactly the following cycle. A rejected write changes nothing and produces no pulse.
- R10: Every read returns its data in the cycle after the request, with `rvalid_o` high. Unmapped offsets read as zero, and bits 1:0 of the offset are ignored.
- R11: Writes to the address and count registers are ignored and do not clear an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | 3 | Per-class error event pulse |
| evt_addr_i | input | 3x64 | Per-class failing address |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | OFFS_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 3 | Per-class level interrupt |
| way_max_o | output | 8 | Largest enabled way index |
| inj_bit_o | output | 8 | Injection bit select |
| inj_sel_o | output | 1 | Injection target selector |
| inj_go_o | output | 1 | One-cycle injection trigger |

## Verification
A wrong class state becomes visible at the ports within one cycle of the next register read:

- A lost or doubled increment shows up as a count that disagrees with the number of pulses sent.
- A stale or mis-steered capture shows up in the address words.
- An interrupt that is cleared by the wrong access, or not cleared at all, is seen on `irq_o` right after the clock edge that accepted the access.

The bench counts events well past the small counter's ceiling, sweeps every injection value and every offset, and drives an event against a same-class count read, so that errors in saturation, decoding and the clear/set race all show up at once.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

    localparam int NUM_CLASSES = 3;

    typedef enum logic [1:0] {
        CLS_DIR_FIX  = 2'd0,
        CLS_DATA_FIX = 2'd1,
        CLS_DATA_BAD = 2'd2
    } err_class_e;

    localparam int unsigned OFF_GEOM   = 32'h000;
    localparam int unsigned OFF_WAYLIM = 32'h008;
    localparam int unsigned OFF_INJECT = 32'h040;
    localparam int unsigned OFF_LO     = 32'h0;
    localparam int unsigned OFF_HI     = 32'h4;
    localparam int unsigned OFF_CNT    = 32'h8;

    typedef struct packed {
        logic       sel;
        logic [7:0] bits;
    } inj_ctl_t;

    function automatic int unsigned class_base(input int c);
        case (c)
            0:       return 32'h100;
            1:       return 32'h140;
            default: return 32'h160;
        endcase
    endfunction

    function automatic logic inj_legal(input logic [31:0] v);
        return (v[7:0] != 8'hFF) && ((v & ~32'h0001_00FF) == 32'h0);
    endfunction

    function automatic logic [31:0] geom_word(input int banks, input int ways,
                                              input int lsets, input int lblk);
        return {8'(lblk), 8'(lsets), 8'(ways), 8'(banks)};
    endfunction

endpackage

// File: rtl/ecc_err_class.sv
module ecc_err_class #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              evt_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic              cnt_rd_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [CNT_W-1:0]  cnt_q_o,
    output logic              irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_q_o <= '0;
            cnt_q_o  <= '0;
            irq_o    <= 1'b0;
        end else begin
            if (evt_i) begin
                addr_q_o <= evt_addr_i;
                if (cnt_q_o != CNT_MAX) cnt_q_o <= cnt_q_o + 1'b1;
            end
            // A same-cycle event wins over the clear caused by a count read.
            if (evt_i)         irq_o <= 1'b1;
            else if (cnt_rd_i) irq_o <= 1'b0;
        end
    end

    assert_capture_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> addr_q_o == $past(evt_addr_i));
    assert_incr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i && cnt_q_o != CNT_MAX) |=> cnt_q_o == $past(cnt_q_o) + 1'b1);
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q_o == CNT_MAX) |=> cnt_q_o == CNT_MAX);
    assert_irq_set_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> irq_o);
    assert_irq_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !cnt_rd_i) |=> irq_o);
    assert_irq_clr_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_rd_i && !evt_i) |=> !irq_o);
    assert_collide_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_rd_i && evt_i) |=> irq_o);
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
    import ecc_rpt_pkg::*;
#(
    parameter int OFFS_W = 9,
    parameter int WAYS   = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [OFFS_W-1:0] off_i,
    input  logic [31:0]       wdata_i,
    output logic [7:0]        way_q_o,
    output inj_ctl_t          inj_q_o,
    output logic              inj_go_o
);
    localparam logic [31:0] WAY_TOP = 32'(WAYS - 1);

    logic hit_way, hit_inj, way_ok, inj_ok;

    always_comb begin
        hit_way = wr_i && (off_i == OFFS_W'(OFF_WAYLIM));
        hit_inj = wr_i && (off_i == OFFS_W'(OFF_INJECT));
        way_ok  = hit_way && (wdata_i <= WAY_TOP);
        inj_ok  = hit_inj && inj_legal(wdata_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            way_q_o  <= '0;
            inj_q_o  <= '0;
            inj_go_o <= 1'b0;
        end else begin
            inj_go_o <= inj_ok;
            if (way_ok) way_q_o <= wdata_i[7:0];
            if (inj_ok) inj_q_o <= '{sel: wdata_i[16], bits: wdata_i[7:0]};
        end
    end

    assert_way_range_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(way_q_o) <= WAY_TOP);
    assert_inj_legal_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        inj_go_o |-> inj_q_o.bits != 8'hFF);
    assert_inj_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !inj_go_o |-> $stable(inj_q_o) || $past(rst_i));
endmodule

// File: rtl/ecc_rd_mux.sv
module ecc_rd_mux
    import ecc_rpt_pkg::*;
#(
    parameter int OFFS_W = 9,
    parameter int CNT_W  = 32
) (
    input  logic [OFFS_W-1:0]                   off_i,
    input  logic [31:0]                         geom_i,
    input  logic [7:0]                          way_i,
    input  inj_ctl_t                            inj_i,
    input  logic [NUM_CLASSES-1:0][63:0]        addr_i,
    input  logic [NUM_CLASSES-1:0][CNT_W-1:0]   cnt_i,
    output logic [31:0]                         data_o,
    output logic [NUM_CLASSES-1:0]              cnt_hit_o
);
    always_comb begin
        data_o    = '0;
        cnt_hit_o = '0;
        if (off_i == OFFS_W'(OFF_GEOM))   data_o = geom_i;
        if (off_i == OFFS_W'(OFF_WAYLIM)) data_o = 32'(way_i);
        if (off_i == OFFS_W'(OFF_INJECT)) data_o = {15'd0, inj_i.sel, 8'd0, inj_i.bits};
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (off_i == OFFS_W'(class_base(c) + OFF_LO)) data_o = addr_i[c][31:0];
            if (off_i == OFFS_W'(class_base(c) + OFF_HI)) data_o = addr_i[c][63:32];
            if (off_i == OFFS_W'(class_base(c) + OFF_CNT)) begin
                data_o       = 32'(cnt_i[c]);
                cnt_hit_o[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_ecc_status.sv
module cache_ecc_status
    import ecc_rpt_pkg::*;
#(
    parameter int OFFS_W    = 9,
    parameter int CNT_W     = 32,
    parameter int BANKS     = 4,
    parameter int WAYS      = 16,
    parameter int LOG2_SETS = 9,
    parameter int LOG2_BLK  = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [2:0]           evt_i,
    input  logic [2:0][63:0]     evt_addr_i,
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [OFFS_W-1:0]    addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output logic                 rvalid_o,
    output logic [2:0]           irq_o,
    output logic [7:0]           way_max_o,
    output logic [7:0]           inj_bit_o,
    output logic                 inj_sel_o,
    output logic                 inj_go_o
);
    localparam logic [31:0] GEOM = geom_word(BANKS, WAYS, LOG2_SETS, LOG2_BLK);

    logic [OFFS_W-1:0]                  off;
    logic                               rd, wr;
    logic [NUM_CLASSES-1:0][63:0]       cls_addr;
    logic [NUM_CLASSES-1:0][CNT_W-1:0]  cls_cnt;
    logic [NUM_CLASSES-1:0]             cnt_hit;
    logic [31:0]                        mux_data;
    inj_ctl_t                           inj_q;

    assign off = {addr_i[OFFS_W-1:2], 2'b00};
    assign rd  = req_i && !we_i;
    assign wr  = req_i && we_i;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        ecc_err_class #(.ADDR_W(64), .CNT_W(CNT_W)) cls_i (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .evt_i      (evt_i[c]),
            .evt_addr_i (evt_addr_i[c]),
            .cnt_rd_i   (rd && cnt_hit[c]),
            .addr_q_o   (cls_addr[c]),
            .cnt_q_o    (cls_cnt[c]),
            .irq_o      (irq_o[c])
        );
    end

    ecc_rd_mux #(.OFFS_W(OFFS_W), .CNT_W(CNT_W)) mux_i (
        .off_i     (off),
        .geom_i    (GEOM),
        .way_i     (way_max_o),
        .inj_i     (inj_q),
        .addr_i    (cls_addr),
        .cnt_i     (cls_cnt),
        .data_o    (mux_data),
        .cnt_hit_o (cnt_hit)
    );

    ecc_ctrl_regs #(.OFFS_W(OFFS_W), .WAYS(WAYS)) ctrl_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_i     (wr),
        .off_i    (off),
        .wdata_i  (wdata_i),
        .way_q_o  (way_max_o),
        .inj_q_o  (inj_q),
        .inj_go_o (inj_go_o)
    );

    assign inj_bit_o = inj_q.bits;
    assign inj_sel_o = inj_q.sel;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd;
            if (rd) rdata_o <= mux_data;
        end
    end

    assert_rvalid_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        rd |=> rvalid_o);
    assert_rvalid_only_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd |=> !rvalid_o);
    assert_cnt_hit_onehot_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(cnt_hit));
    assert_write_keeps_irq_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr && evt_i == 3'b000) |=> irq_o == $past(irq_o));
endmodule

// File: tb/cache_ecc_status_tb_top.sv
`timescale 1ns/1ps
module cache_ecc_status_tb_top;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;
    localparam int WAYS = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       evt = '0;
    logic [2:0][63:0] evt_addr = '0;
    logic             req = 1'b0, we = 1'b0;
    logic [8:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             rvalid, inj_sel, inj_go;
    logic [2:0]       irq;
    logic [7:0]       way_max, inj_bit;

    int checks = 0, failures = 0;
    bit done = 0;

    int        exp_cnt [3];
    logic [63:0] exp_addr [3];
    logic [2:0]  exp_irq;
    logic [7:0]  exp_way, exp_bits;
    logic        exp_sel;

    always #2.5 clk = ~clk;

    cache_ecc_status #(.OFFS_W(9), .CNT_W(CW), .BANKS(2), .WAYS(WAYS),
                       .LOG2_SETS(5), .LOG2_BLK(6)) dut_i (
        .clk_i(clk), .rst_i(rst), .evt_i(evt), .evt_addr_i(evt_addr),
        .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq), .way_max_o(way_max),
        .inj_bit_o(inj_bit), .inj_sel_o(inj_sel), .inj_go_o(inj_go));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int base(input int c);
        return (c == 0) ? 'h100 : (c == 1) ? 'h140 : 'h160;
    endfunction

    task automatic rd(input int off, output logic [31:0] d);
        @(negedge clk);
        req = 1; we = 0; addr = 9'(off);
        @(negedge clk);
        req = 0;
        d = rdata;
        chk("R10 rvalid", 64'(rvalid), 64'd1);
        if (off == base(0) + 8) exp_irq[0] = 0;
        if (off == base(1) + 8) exp_irq[1] = 0;
        if (off == base(2) + 8) exp_irq[2] = 0;
    endtask

    task automatic wr(input int off, input logic [31:0] v, output logic go);
        @(negedge clk);
        req = 1; we = 1; addr = 9'(off); wdata = v;
        @(negedge clk);
        req = 0; we = 0;
        go = inj_go;
    endtask

    task automatic fire(input int c, input logic [63:0] a);
        @(negedge clk);
        evt[c] = 1; evt_addr[c] = a;
        @(negedge clk);
        evt = '0;
        exp_addr[c] = a;
        exp_cnt[c]  = (exp_cnt[c] < CMAX) ? exp_cnt[c] + 1 : CMAX;
        exp_irq[c]  = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic go;
        for (int c = 0; c < 3; c++) begin exp_cnt[c] = 0; exp_addr[c] = '0; end
        exp_irq = '0; exp_way = '0; exp_bits = '0; exp_sel = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 way", 64'(way_max), 64'd0);
        chk("R1 inj", 64'({inj_sel, inj_bit, inj_go}), 64'd0);
        for (int c = 0; c < 3; c++) begin
            rd(base(c), d);     chk("R1 addr lo", 64'(d), 64'd0);
            rd(base(c) + 4, d); chk("R1 addr hi", 64'(d), 64'd0);
            rd(base(c) + 8, d); chk("R1 count", 64'(d), 64'd0);
        end
        rd('h40, d); chk("R1 inject reg", 64'(d), 64'd0);

        // R7: geometry word, writes ignored
        rd('h00, d); chk("R7 geometry", 64'(d), 64'h0605_0402);
        wr('h00, 32'hFFFF_FFFF, go);
        rd('h00, d); chk("R7 geometry after write", 64'(d), 64'h0605_0402);

        // R5: event colliding with same-class count read
        fire(1, 64'h1111_2222_3333_4444);
        @(negedge clk);
        req = 1; we = 0; addr = 9'(base(1) + 8);
        evt[1] = 1; evt_addr[1] = 64'h5555_6666_7777_8888;
        @(negedge clk);
        req = 0; evt = '0;
        chk("R5 read returns pre-event count", 64'(rdata), 64'd1);
        chk("R5 irq stays high", 64'(irq[1]), 64'd1);
        exp_cnt[1] = 2; exp_addr[1] = 64'h5555_6666_7777_8888; exp_irq[1] = 1;
        rd(base(1) + 8, d); chk("R5 count incremented", 64'(d), 64'd2);
        chk("R4 irq cleared by count read", 64'(irq), 64'(exp_irq));

        // R2..R4, R6: sweep each class past saturation
        for (int c = 0; c < 3; c++) begin
            for (int k = 1; k <= CMAX + 3; k++) begin
                logic [63:0] a;
                a = {32'hA000_0000 | 32'(c << 16) | 32'(k), 32'h1234_0000 + 32'(k * 3)};
                fire(c, a);
                chk("R4/R6 irq after event", 64'(irq), 64'(exp_irq));
                rd(base(c), d);     chk("R2 addr lo", 64'(d), 64'(exp_addr[c][31:0]));
                rd(base(c) + 4, d); chk("R2 addr hi", 64'(d), 64'(exp_addr[c][63:32]));
                chk("R4 addr read keeps irq", 64'(irq[c]), 64'd1);
                rd(base(c) + 8, d); chk("R3 count", 64'(d), 64'(exp_cnt[c]));
                chk("R4/R6 irq after count read", 64'(irq), 64'(exp_irq));
            end
            for (int o = 0; o < 3; o++) begin
                rd(base(o) + 8, d); chk("R6 other counts", 64'(d), 64'(exp_cnt[o]));
                rd(base(o), d);     chk("R6 other addr", 64'(d), 64'(exp_addr[o][31:0]));
            end
        end

        // R2: last error wins
        fire(2, 64'hDEAD_0000_0000_0001);
        fire(2, 64'hBEEF_0000_0000_0002);
        rd(base(2), d);     chk("R2 last wins lo", 64'(d), 64'h2);
        rd(base(2) + 4, d); chk("R2 last wins hi", 64'(d), 64'hBEEF_0000);

        // R11: writes to address/count ignored, irq kept
        fire(0, 64'h0000_00AB_0000_00CD);
        wr(base(0) + 8, 32'h0, go);
        wr(base(0), 32'h0, go);
        wr(base(0) + 4, 32'h0, go);
        chk("R11 irq survives writes", 64'(irq[0]), 64'd1);
        rd(base(0), d);     chk("R11 addr lo unchanged", 64'(d), 64'hCD);
        rd(base(0) + 4, d); chk("R11 addr hi unchanged", 64'(d), 64'hAB);
        rd(base(0) + 8, d); chk("R11 count unchanged", 64'(d), 64'(exp_cnt[0]));
        chk("R4 irq cleared", 64'(irq[0]), 64'd0);

        // R8: way limit sweep
        for (int v = 0; v < 10; v++) begin
            for (int s = 0; s < 2; s++) begin
                int val;
                val = s ? 9 - v : v;
                wr('h08, 32'(val), go);
                if (val <= WAYS - 1) exp_way = 8'(val);
                chk("R8 way output", 64'(way_max), 64'(exp_way));
                rd('h08, d); chk("R8 way readback", 64'(d), 64'(exp_way));
            end
        end
        wr('h08, 32'h0000_0102, go);
        chk("R8 wide value rejected", 64'(way_max), 64'(exp_way));

        // R9: injection sweep
        for (int hi = 0; hi < 3; hi++) begin
            for (int b = 0; b < 256; b++) begin
                logic [31:0] v;
                logic legal;
                v = (hi == 0) ? 32'(b) : (hi == 1) ? (32'h1_0000 | 32'(b)) : (32'h2_0000 | 32'(b));
                legal = (b != 255) && (hi != 2);
                wr('h40, v, go);
                if (legal) begin exp_bits = 8'(b); exp_sel = (hi == 1); end
                chk("R9 go pulse", 64'(go), 64'(legal));
                chk("R9 outputs", 64'({inj_sel, inj_bit}), 64'({exp_sel, exp_bits}));
                rd('h40, d);
                chk("R9 readback", 64'(d), {47'd0, exp_sel, 8'd0, exp_bits});
                chk("R9 pulse one cycle", 64'(inj_go), 64'd0);
            end
        end

        // R10: unmapped offsets and ignored low bits
        for (int off = 0; off < 'h200; off += 4) begin
            bit mapped;
            mapped = (off == 0) || (off == 8) || (off == 'h40);
            for (int c = 0; c < 3; c++)
                if (off == base(c) || off == base(c) + 4 || off == base(c) + 8) mapped = 1;
            if (!mapped) begin
                rd(off, d); chk("R10 unmapped zero", 64'(d), 64'd0);
            end
        end
        rd('h02, d); chk("R10 low bits ignored", 64'(d), 64'h0605_0402);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule